// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Selectable Periodic Tap

This block is the timing front end of a real-time clock. A slow 32.768 kHz reference reaches it as a one-cycle enable pulse on a fast system clock. Fifteen cascaded divide-by-two stages turn that reference into a once-per-second update strobe, which a downstream seconds counter consumes. A three-bit mode field either lets the chain count or pins every stage at zero. Releasing the chain from that hold gives a predictable phase: the first update arrives half a second after release.

A four-bit rate field picks one stage of the chain as the source of a periodic event. Each rising edge of the picked stage sets a sticky flag, which stays set until a one-cycle clear pulse arrives. An interrupt output reports the flag qualified by an enable input. Because the chain starts from zero, the first periodic event after release comes half of the selected period later.

Top module: `rtc_prescaler`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `upd_pulse`, `per_flag` and `per_irq` are all 0.
- R2: The chain counts only when `div_mode` is 3'b010, 3'b011 or 3'b100. Every other value holds all stages at zero and keeps both `upd_pulse` and new flag events off.
- R3: The chain advances by one only in cycles where `tick_en` is 1. Cycles without `tick_en` leave its state unchanged.
- R4: After release into a counting mode, `upd_pulse` is first 1 on the clock edge that samples the 16384th `tick_en`. It then repeats every 32768 ticks.
- R5: `upd_pulse` is high for exactly one system-clock cycle per update.
- R6: A `rate_sel` of 0 never sets `per_flag`.
- R7: A `rate_sel` of n (1 to 15) sets `per_flag` on the edge that samples tick number 2^(n-1) after release, and then every 2^n ticks after that.
- R8: `per_flag` stays set until a cycle with `flag_clr` high. If a set event and `flag_clr` fall in the same cycle, the flag remains set.
- R9: `per_irq` is registered together with `per_flag` and equals the next flag value ANDed with `irq_en` sampled in the same cycle.
- R10: Dropping into a hold mode and returning to a counting mode restarts the phase. The first update and the first periodic event again follow R4 and R7, counted from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| div_mode | input | 3 | Chain mode: 010, 011 or 100 count; all other values hold the chain at zero |
| rate_sel | input | 4 | Periodic tap select: 0 off, n selects stage n |
| irq_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | One-cycle clear of the periodic flag |
| upd_pulse | output | 1 | One-cycle once-per-second update strobe |
| per_flag | output | 1 | Sticky periodic event flag |
| per_irq | output | 1 | Periodic flag qualified by `irq_en` |

## Verification
The assertions assume that `div_mode` and `rate_sel` are stable system-clock inputs. They also assume that `tick_en` is a single-cycle pulse, so that an update strobe can never fall in two adjacent cycles. The stimulus drives every input just after the rising edge. It spaces reference ticks one to three system cycles apart, and it changes mode and rate only between runs. The flag clear is applied as isolated pulses, some of them placed on the same cycle as a set event.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;
  localparam int unsigned CHAIN_STAGES = 15;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_HOLD0 = 3'b000,
    MODE_HOLD1 = 3'b001,
    MODE_RUN_A = 3'b010,
    MODE_RUN_B = 3'b011,
    MODE_RUN_C = 3'b100,
    MODE_HOLD5 = 3'b101,
    MODE_HOLD6 = 3'b110,
    MODE_HOLD7 = 3'b111
  } div_mode_e;

  function automatic logic mode_counts(input logic [MODE_W-1:0] m);
    return (m == MODE_RUN_A) || (m == MODE_RUN_B) || (m == MODE_RUN_C);
  endfunction
endpackage

// File: rtl/rtc_div_mode_decode.sv
module rtc_div_mode_decode
  import rtc_div_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              run_o
);
  always_comb begin
    run_o = mode_counts(mode_i);
  end
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
  parameter int unsigned STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              tick_i,
  output logic [STAGES-1:0] stage_q_o,
  output logic [STAGES-1:0] rise_o
);
  logic [STAGES-1:0] q_r;
  logic [STAGES:0]   carry;
  logic [STAGES-1:0] rise_raw;

  assign carry[0] = tick_i;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      assign carry[k+1]  = carry[k] & q_r[k];
      assign rise_raw[k] = carry[k] & ~q_r[k];
      always_ff @(posedge clk) begin
        if (rst || !run_i) begin
          q_r[k] <= 1'b0;
        end else if (carry[k]) begin
          q_r[k] <= ~q_r[k];
        end
      end
    end
  endgenerate

  assign rise_o    = run_i ? rise_raw : '0;
  assign stage_q_o = q_r;

  p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (stage_q_o == '0));
  p_tick_only_r3: assert property (@(posedge clk) disable iff (rst)
    (run_i && !tick_i) |=> $stable(stage_q_o));
  p_rise_single_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rise_o));
endmodule

// File: rtl/rtc_div_periodic.sv
module rtc_div_periodic #(
  parameter int unsigned STAGES = 15,
  parameter int unsigned RATE_W = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] rise_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              irq_en_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic tap_hit;
  logic flag_r;
  logic irq_r;
  logic flag_next;

  always_comb begin
    tap_hit = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      if (rate_i == RATE_W'(i + 1)) begin
        tap_hit = rise_i[i];
      end
    end
  end

  assign flag_next = (flag_r & ~clr_i) | tap_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_r <= 1'b0;
      irq_r  <= 1'b0;
    end else begin
      flag_r <= flag_next;
      irq_r  <= flag_next & irq_en_i;
    end
  end

  assign flag_o = flag_r;
  assign irq_o  = irq_r;

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
  p_rate_off_r6: assert property (@(posedge clk) disable iff (rst)
    (rate_i == '0 && !flag_o) |=> !flag_o);
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_div_pkg::*;
#(
  parameter int unsigned STAGES = CHAIN_STAGES,
  parameter int unsigned RATE_W = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [MODE_W-1:0] div_mode,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              upd_pulse,
  output logic              per_flag,
  output logic              per_irq
);
  logic              run;
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_rise;
  logic              upd_r;

  rtc_div_mode_decode u_decode (
    .mode_i (div_mode),
    .run_o  (run)
  );

  rtc_div_chain #(.STAGES(STAGES)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run),
    .tick_i    (tick_en),
    .stage_q_o (stage_q),
    .rise_o    (stage_rise)
  );

  rtc_div_periodic #(.STAGES(STAGES), .RATE_W(RATE_W)) u_periodic (
    .clk      (clk),
    .rst      (rst),
    .rise_i   (stage_rise),
    .rate_i   (rate_sel),
    .irq_en_i (irq_en),
    .clr_i    (flag_clr),
    .flag_o   (per_flag),
    .irq_o    (per_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_r <= 1'b0;
    end else begin
      upd_r <= stage_rise[STAGES-1];
    end
  end

  assign upd_pulse = upd_r;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!upd_pulse && !per_flag && !per_irq));
  p_hold_no_update_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !upd_pulse);
  p_update_single_r5: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> !upd_pulse);
  p_update_on_top_stage_r4: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> stage_q[STAGES-1]);
endmodule

// File: tb/test_rtc_prescaler.sv
module test_rtc_prescaler;
  localparam int NST = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [2:0] div_mode = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic       irq_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       upd_pulse, per_flag, per_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  int  m_ticks = 0;
  bit  m_upd = 0, m_flag = 0, m_irq = 0;
  int  seen_upd = 0;
  int  seen_flag_sets = 0;
  int  ticks_since_release = 0;
  int  first_upd_tick = -1;
  bit  prev_flag = 0;

  always #4 clk = ~clk;

  rtc_prescaler i_rtc_prescaler (
    .clk(clk), .rst(rst), .tick_en(tick_en), .div_mode(div_mode),
    .rate_sel(rate_sel), .irq_en(irq_en), .flag_clr(flag_clr),
    .upd_pulse(upd_pulse), .per_flag(per_flag), .per_irq(per_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic bit counting(input logic [2:0] m);
    return m == 3'b010 || m == 3'b011 || m == 3'b100;
  endfunction

  always @(posedge clk) begin
    bit hit;
    int half;
    cycles++;
    started = 1;
    hit = 0;
    if (rst) begin
      m_ticks = 0; m_upd = 0; m_flag = 0; m_irq = 0;
      ticks_since_release = 0;
    end else begin
      m_upd = 0;
      if (!counting(div_mode)) begin
        m_ticks = 0;
        ticks_since_release = 0;
      end else if (tick_en) begin
        m_ticks = (m_ticks + 1) % 32768;
        ticks_since_release++;
        m_upd = (m_ticks == 16384);
        if (rate_sel != 0) begin
          half = 1 << (rate_sel - 1);
          hit = (m_ticks % (2 * half)) == half;
        end
      end
      m_flag = (m_flag && !flag_clr) || hit;
      m_irq = m_flag && irq_en;
    end
    if (cycles > 190000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(upd_pulse === m_upd, "R4 upd_pulse", upd_pulse, m_upd);
      check(per_flag === m_flag, "R7 per_flag", per_flag, m_flag);
      check(per_irq === m_irq, "R9 per_irq", per_irq, m_irq);
      if (upd_pulse === 1'b1) begin
        seen_upd++;
        if (first_upd_tick < 0) first_upd_tick = ticks_since_release;
      end
      if (per_flag === 1'b1 && !prev_flag) seen_flag_sets++;
      prev_flag = (per_flag === 1'b1);
    end
  end

  task automatic step(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      tick_en = (gap <= 1) ? 1'b1 : ((i % gap) == 0);
      flag_clr = 1'b0;
    end
    @(posedge clk); #2;
    tick_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(posedge clk); #2;
    tick_en = 1'b0; flag_clr = 1'b1;
    @(posedge clk); #2;
    flag_clr = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m, input logic [3:0] r);
    @(posedge clk); #2;
    tick_en = 1'b0; div_mode = m; rate_sel = r;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // R1: reset state
    check(upd_pulse === 0 && per_flag === 0 && per_irq === 0, "R1 reset outputs",
          {upd_pulse, per_flag, per_irq}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(upd_pulse === 0 && per_flag === 0 && per_irq === 0, "R1 first cycle",
          {upd_pulse, per_flag, per_irq}, 0);

    // R2: hold encodings keep everything quiet
    for (int m = 0; m < 8; m++) begin
      if (!counting(3'(m))) begin
        set_mode(3'(m), 4'd1);
        seen_flag_sets = 0; seen_upd = 0;
        step(40, 1);
        check(seen_flag_sets == 0 && seen_upd == 0, "R2 hold mode", seen_flag_sets + seen_upd, 0);
      end
    end

    // R7 + R9: rate 3 in mode 010, irq enabled, periodic clears
    irq_en = 1'b1;
    set_mode(3'b010, 4'd3);
    for (int k = 0; k < 6; k++) begin
      step(7, 1);
      pulse_clr();
    end

    // R6: rate 0 never sets
    pulse_clr();
    set_mode(3'b011, 4'd0);
    seen_flag_sets = 0;
    step(400, 1);
    check(seen_flag_sets == 0 && per_flag === 0, "R6 rate off", seen_flag_sets, 0);

    // R3: sparse ticks, rate 5, irq disabled
    irq_en = 1'b0;
    set_mode(3'b000, 4'd5);
    set_mode(3'b100, 4'd5);
    seen_flag_sets = 0;
    step(48, 3);
    check(per_flag === 1'b1 && seen_flag_sets == 1, "R3 first event after 16 ticks",
          seen_flag_sets, 1);
    pulse_clr();
    step(45, 3);
    check(per_flag === 1'b0, "R3 no event before tick 48", per_flag, 0);

    // R8: sticky flag and clear colliding with a set
    irq_en = 1'b1;
    set_mode(3'b000, 4'd1);
    set_mode(3'b010, 4'd1);
    step(2, 1);
    repeat (20) @(posedge clk);
    #1;
    check(per_flag === 1'b1, "R8 sticky hold", per_flag, 1);
    @(posedge clk); #2;
    tick_en = 1'b1; flag_clr = 1'b1; // tick 2 -> tick 3 is a set for rate 1
    @(posedge clk); #2;
    tick_en = 1'b0; flag_clr = 1'b0;
    @(negedge clk);
    check(per_flag === 1'b1, "R8 set wins over clear", per_flag, 1);
    pulse_clr();
    @(negedge clk);
    check(per_flag === 1'b0, "R8 cleared", per_flag, 0);

    // R10 + R4: restart, first update at tick 16384, next 32768 later
    set_mode(3'b000, 4'd15);
    set_mode(3'b100, 4'd15);
    seen_upd = 0; first_upd_tick = -1;
    step(16390, 1);
    check(seen_upd == 1, "R4 one update after half second", seen_upd, 1);
    check(first_upd_tick == 16384, "R10 first update phase", first_upd_tick, 16384);
    check(per_flag === 1'b1, "R7 rate 15 half period", per_flag, 1);
    pulse_clr();
    step(32768, 1);
    check(seen_upd == 2, "R4 second update", seen_upd, 2);
    check(per_flag === 1'b1, "R7 rate 15 full period", per_flag, 1);

    // R5: pulse width, restart mid-count then recheck phase
    set_mode(3'b011, 4'd15);
    step(5000, 1);
    set_mode(3'b001, 4'd15);
    set_mode(3'b011, 4'd15);
    seen_upd = 0; first_upd_tick = -1;
    step(16386, 1);
    check(first_upd_tick == 16384, "R10 restart after partial count", first_upd_tick, 16384);
    check(seen_upd == 1, "R5 single pulse per update", seen_upd, 1);

    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule